// File: doc/BRIEF.md
# Code Bus Master for an External Compressed-Data FIFO

This block moves compressed bytes between an internal code buffer and an external FIFO over an 8-bit code bus, with the block as the bus master. It runs on a double-rate clock. Every transfer is a fixed cycle of four ticks. The first tick pulls the active-low chip select down. The next two ticks hold the read or write strobe low. The last tick releases the strobe and keeps chip select low. The strobe therefore falls one double-rate tick, which is half a base-rate period, after the cycle opens.

Toward the internal buffer the block offers two valid/ready handshakes. It takes bytes in for outward writes when in compression mode, and hands captured bytes back in decompression mode. The external FIFO controller can hold off new cycles with an active-low busy line. A cycle that has already started always runs to its end. The bidirectional code bus is presented as separate input, output and output-enable pins, and the pad ring merges them.

Top module: `codebus_master`

## Requirements
- R1: While reset is asserted and after it is released, until the first cycle starts, `cs_n`, `rd_n` and `wr_n` are 1 and `code_oe` is 0.
- R2: A transfer cycle lasts four clock ticks. Chip select is low for all four. The selected strobe is low on ticks two and three only, so it falls exactly one tick after the cycle begins and stays low for `STRB_TICKS` (default 2) ticks.
- R3: When the next transfer can start at the release tick, the new cycle follows at once. Chip select stays low with no high tick between cycles, so N chained cycles give exactly 4N consecutive low ticks.
- R4: With `dir_write`=1, a byte accepted on the `tx_valid`/`tx_ready` handshake is driven on `code_out` with `code_oe`=1 for the whole cycle. It is held unchanged while `wr_n` is low, and bytes leave in the order they were accepted.
- R5: With `dir_write`=0, `code_in` is captured on the clock edge at which `rd_n` returns high. The byte is offered on `rx_valid`/`rx_data` in bus order, with a one-byte holding stage.
- R6: A read cycle starts only if the holding stage is empty or is emptied in the same tick. No byte is lost or repeated when `rx_ready` stalls.
- R7: `busy_n` is looked at only at cycle boundaries (idle or release tick). A strobe can fall only if `busy_n` was 1 at the edge that opened its cycle. A cycle already running completes.
- R8: The direction (1 = write out, 0 = read in) is fixed at the start of each cycle, and `tx_ready` is 0 whenever `dir_write` is 0.
- R9: The two strobes are never low together, and neither is low while `cs_n` is high. `code_oe` is 1 only during write cycles and never while `rd_n` is low.
- R10: With nothing to send in write mode, the bus stays idle: `cs_n` high and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_write | input | 1 | 1 = write bytes outward, 0 = read bytes inward |
| tx_valid | input | 1 | Internal buffer has a byte to send |
| tx_ready | output | 1 | Block accepts the byte this tick |
| tx_data | input | DATA_W | Byte to send |
| rx_valid | output | 1 | Captured byte available |
| rx_ready | input | 1 | Internal buffer takes the captured byte |
| rx_data | output | DATA_W | Captured byte |
| busy_n | input | 1 | Active-low hold-off from the external FIFO controller |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| code_in | input | DATA_W | Code bus input side |
| code_out | output | DATA_W | Code bus output side |
| code_oe | output | 1 | Code bus output enable |

## Verification
The bench drives long chained bursts in both directions. A design that dropped chip select between cycles would show extra high ticks or more than one rise of `cs_n`. A design that placed the strobe at the wrong tick would break the setup-tick check before each falling strobe. Read capture one edge late would return each byte shifted by one, because the modelled FIFO moves to its next byte right after each `rd_n` rise. Random busy and random `rx_ready` stalls show whether a design starts a cycle while held off, or loses or repeats a byte when the holding stage is full. A direction change between streams shows whether a stale direction leaks into the first cycle of the new stream.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SETUP   = 2'd1,
        PH_STROBE  = 2'd2,
        PH_RELEASE = 2'd3
    } phase_e;

endpackage

// File: rtl/cbm_sequencer.sv
module cbm_sequencer
    import cbm_pkg::*;
#(
    parameter int STRB_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_n,
    input  logic dir_write,
    input  logic wr_avail,
    input  logic rd_room,
    output logic tx_ready,
    output logic start_wr,
    output logic cap_rd,
    output logic cs_n,
    output logic rd_n,
    output logic wr_n,
    output logic drive_en
);

    localparam int CNT_W = (STRB_TICKS > 1) ? $clog2(STRB_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STRB_TICKS - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             cyc_wr;
        logic             cs_n;
        logic             rd_n;
        logic             wr_n;
        logic             oe;
    } seq_t;

    seq_t seq_d, seq_q;
    logic at_bnd;
    logic rd_go;

    always_comb begin
        seq_d    = seq_q;
        at_bnd   = (seq_q.ph == PH_IDLE) || (seq_q.ph == PH_RELEASE);
        tx_ready = at_bnd && busy_n && dir_write;
        start_wr = tx_ready && wr_avail;
        rd_go    = at_bnd && busy_n && !dir_write && rd_room;
        cap_rd   = (seq_q.ph == PH_STROBE) && (seq_q.cnt == CNT_LAST) && !seq_q.cyc_wr;

        case (seq_q.ph)
            PH_IDLE, PH_RELEASE: begin
                if (start_wr || rd_go) begin
                    seq_d.ph     = PH_SETUP;
                    seq_d.cyc_wr = start_wr;
                end else begin
                    seq_d.ph     = PH_IDLE;
                end
            end
            PH_SETUP: begin
                seq_d.ph  = PH_STROBE;
                seq_d.cnt = '0;
            end
            PH_STROBE: begin
                if (seq_q.cnt == CNT_LAST) begin
                    seq_d.ph = PH_RELEASE;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.ph = PH_IDLE;
        endcase

        seq_d.cs_n = (seq_d.ph == PH_IDLE);
        seq_d.rd_n = !((seq_d.ph == PH_STROBE) && !seq_d.cyc_wr);
        seq_d.wr_n = !((seq_d.ph == PH_STROBE) && seq_d.cyc_wr);
        seq_d.oe   = (seq_d.ph != PH_IDLE) && seq_d.cyc_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_IDLE, cnt: '0, cyc_wr: 1'b0,
                       cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, oe: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cs_n     = seq_q.cs_n;
    assign rd_n     = seq_q.rd_n;
    assign wr_n     = seq_q.wr_n;
    assign drive_en = seq_q.oe;

endmodule

// File: rtl/cbm_tx_path.sv
module cbm_tx_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] code_out
);

    typedef struct packed {
        logic [DATA_W-1:0] dat;
    } txp_t;

    txp_t txp_d, txp_q;

    always_comb begin
        txp_d = txp_q;
        if (start_wr) begin
            txp_d.dat = tx_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txp_q <= '0;
        end else begin
            txp_q <= txp_d;
        end
    end

    assign code_out = txp_q.dat;

endmodule

// File: rtl/cbm_rx_path.sv
module cbm_rx_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_rd,
    input  logic [DATA_W-1:0] code_in,
    input  logic              rx_ready,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rd_room
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] dat;
    } rxp_t;

    rxp_t rxp_d, rxp_q;

    always_comb begin
        rxp_d = rxp_q;
        if (cap_rd) begin
            rxp_d.full = 1'b1;
            rxp_d.dat  = code_in;
        end else if (rx_ready) begin
            rxp_d.full = 1'b0;
        end
        rd_room = !rxp_q.full || rx_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxp_q <= '0;
        end else begin
            rxp_q <= rxp_d;
        end
    end

    assign rx_valid = rxp_q.full;
    assign rx_data  = rxp_q.dat;

endmodule

// File: rtl/codebus_master.sv
module codebus_master #(
    parameter int DATA_W     = 8,
    parameter int STRB_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_write,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [DATA_W-1:0] tx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [DATA_W-1:0] rx_data,
    input  logic              busy_n,
    output logic              cs_n,
    output logic              rd_n,
    output logic              wr_n,
    input  logic [DATA_W-1:0] code_in,
    output logic [DATA_W-1:0] code_out,
    output logic              code_oe
);

    logic start_wr;
    logic cap_rd;
    logic rd_room;

    cbm_sequencer #(.STRB_TICKS(STRB_TICKS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_n   (busy_n),
        .dir_write(dir_write),
        .wr_avail (tx_valid),
        .rd_room  (rd_room),
        .tx_ready (tx_ready),
        .start_wr (start_wr),
        .cap_rd   (cap_rd),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .drive_en (code_oe)
    );

    cbm_tx_path #(.DATA_W(DATA_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_wr(start_wr),
        .tx_data (tx_data),
        .code_out(code_out)
    );

    cbm_rx_path #(.DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_rd  (cap_rd),
        .code_in (code_in),
        .rx_ready(rx_ready),
        .rx_valid(rx_valid),
        .rx_data (rx_data),
        .rd_room (rd_room)
    );

endmodule

// File: rtl/cbm_master_chk.sv
module cbm_master_chk #(
    parameter int DATA_W     = 8,
    parameter int STRB_TICKS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dir_write,
    input logic              tx_ready,
    input logic              busy_n,
    input logic              cs_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic [DATA_W-1:0] code_out,
    input logic              code_oe
);

    logic [7:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!(rd_n && wr_n)) begin
            low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    // R1: reset puts strobes and select high and releases the bus
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (cs_n && rd_n && wr_n && !code_oe));

    // R2: strobe falls one tick after a select-low setup tick
    assert_strobe_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> $past(!cs_n && rd_n && wr_n));

    // R2: strobe low width equals STRB_TICKS
    assert_strobe_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && wr_n && $past(!(rd_n && wr_n))) |-> (low_run == 8'(STRB_TICKS)));

    // R4: write data held while the write strobe is low
    assert_wdata_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && $past(!wr_n)) |-> ($stable(code_out) && code_oe));

    // R7: no cycle opened while busy was asserted
    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> $past(busy_n, 2));

    // R8: no write acceptance in read mode
    assert_no_txready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_write |-> !tx_ready);

    // R9: strobes exclusive and only under chip select
    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    assert_strobe_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !cs_n);
    assert_bus_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        code_oe |-> (!cs_n && rd_n));

endmodule

bind codebus_master cbm_master_chk #(.DATA_W(DATA_W), .STRB_TICKS(STRB_TICKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_write(dir_write),
    .tx_ready (tx_ready),
    .busy_n   (busy_n),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .code_out (code_out),
    .code_oe  (code_oe)
);

// File: tb/sim_codebus_master.sv
`timescale 1ns/1ps
module sim_codebus_master;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_write = 1'b1;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] tx_data = 8'h00;
    logic       rx_valid;
    logic       rx_ready = 1'b1;
    logic [7:0] rx_data;
    logic       busy_n = 1'b1;
    logic       cs_n, rd_n, wr_n;
    logic [7:0] code_in = 8'h00;
    logic [7:0] code_out;
    logic       code_oe;

    always #2 clk = ~clk;

    codebus_master u0 (
        .clk(clk), .rst_n(rst_n), .dir_write(dir_write),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .busy_n(busy_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .code_in(code_in), .code_out(code_out), .code_oe(code_oe)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ext_byte(input int i);
        return 8'((i * 37 + 11) ^ (i >> 3));
    endfunction

    // stimulus state, set by tasks
    logic [7:0] tx_mem [0:31];
    int  tx_idx = 0, tx_len = 0;
    bit  tx_en = 0, busy_rand = 0, rxr_rand = 0;
    logic [15:0] lfsr = 16'hACE1;

    // observed
    logic [7:0] ext_got [0:63];
    int  ext_wr_n = 0;
    int  ext_rd_idx = 0;
    logic [7:0] got [0:63];
    int  got_n = 0;
    bit  tx_fire = 0;
    logic [1:0] bhist = 2'b11;

    // monitor counters
    int offset_bad = 0, width_bad = 0, busy_bad = 0, wdat_bad = 0, bus_bad = 0;
    int cs_low_cnt = 0, cs_rise_cnt = 0, strb_falls = 0, txr_bad = 0;
    int low_cnt = 0;
    logic [7:0] wdat = 0;
    bit s1_cs = 1, s1_sb = 1, s2_cs = 1, s2_sb = 1, s3_sb = 1, pv_rd = 1, pv_wr = 1;

    // edge samplers
    always @(posedge clk) begin
        tx_fire <= tx_valid && tx_ready;
        bhist   <= {bhist[0], busy_n};
        if (rx_valid && rx_ready && got_n < 64) begin
            got[got_n] <= rx_data;
            got_n      <= got_n + 1;
        end
    end

    // drivers and monitors, away from the active edge
    always @(negedge clk) begin
        bit sb;
        if (tx_fire) tx_idx++;
        tx_valid = tx_en && (tx_idx < tx_len);
        tx_data  = tx_mem[tx_idx % 32];
        lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        busy_n   = busy_rand ? (lfsr[3] | lfsr[7]) : 1'b1;
        rx_ready = rxr_rand ? lfsr[5] : 1'b1;

        if (!pv_rd && rd_n) ext_rd_idx++;
        code_in = ext_byte(ext_rd_idx);
        if (!pv_wr && wr_n && ext_wr_n < 64) begin
            ext_got[ext_wr_n] = code_out;
            ext_wr_n++;
        end

        if (rst_n) begin
            sb = rd_n && wr_n;
            if (s1_sb && !sb) begin
                strb_falls++;
                if (!(!s1_cs && (s2_cs || (s2_sb && !s3_sb)))) offset_bad++;
                if (!bhist[1]) busy_bad++;
            end
            if (!sb) low_cnt++;
            else begin
                if (!s1_sb && low_cnt != 2) width_bad++;
                low_cnt = 0;
            end
            if (pv_wr && !wr_n) wdat = code_out;
            if (!wr_n && (code_out != wdat || !code_oe)) wdat_bad++;
            if (code_oe && (cs_n || !rd_n)) bus_bad++;
            if (!cs_n) cs_low_cnt++;
            if (cs_n && !s1_cs) cs_rise_cnt++;
            if (!dir_write && tx_ready) txr_bad++;
            s3_sb = s2_sb; s2_sb = s1_sb; s2_cs = s1_cs;
            s1_sb = sb;    s1_cs = cs_n;
        end
        pv_rd = rd_n; pv_wr = wr_n;
    end

    task automatic clear_counts();
        offset_bad = 0; width_bad = 0; busy_bad = 0; wdat_bad = 0; bus_bad = 0;
        cs_low_cnt = 0; cs_rise_cnt = 0; strb_falls = 0; txr_bad = 0;
    endtask

    task automatic idle_ticks(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cs_n && rd_n && wr_n && !code_oe, "R1 reset outputs", {cs_n, rd_n, wr_n, code_oe}, 4'b1110);
        @(posedge clk); #1 rst_n = 1'b1;
        idle_ticks(3);
        chk(cs_n && rd_n && wr_n && !code_oe, "R1 after release", {cs_n, rd_n, wr_n, code_oe}, 4'b1110);
    endtask

    task automatic t_idle();
        clear_counts();
        dir_write = 1'b1; tx_en = 0;
        idle_ticks(20);
        chk(cs_low_cnt == 0, "R10 idle select", cs_low_cnt, 0);
        chk(strb_falls == 0, "R10 idle strobes", strb_falls, 0);
    endtask

    task automatic run_write(input int n, input bit rnd_busy, input string tag);
        int base = ext_wr_n;
        int t = 0;
        for (int i = 0; i < n; i++) tx_mem[i] = 8'(8'h5A + i * 29);
        tx_idx = 0; tx_len = n; busy_rand = rnd_busy; dir_write = 1'b1;
        clear_counts();
        tx_en = 1;
        while (ext_wr_n < base + n && t < 20000) begin @(posedge clk); t++; end
        idle_ticks(6);
        tx_en = 0; busy_rand = 0;
        chk(ext_wr_n == base + n, {tag, " byte count"}, ext_wr_n - base, n);
        for (int i = 0; i < n; i++)
            chk(ext_got[(base + i) % 64] == tx_mem[i], {tag, " order"}, ext_got[(base + i) % 64], tx_mem[i]);
        chk(offset_bad == 0, "R2 strobe offset", offset_bad, 0);
        chk(width_bad == 0, "R2 strobe width", width_bad, 0);
        chk(wdat_bad == 0, "R4 data stable under strobe", wdat_bad, 0);
        chk(bus_bad == 0, "R9 bus drive", bus_bad, 0);
        chk(busy_bad == 0, "R7 busy hold-off", busy_bad, 0);
    endtask

    task automatic t_write_burst();
        run_write(8, 0, "R4 burst");
        chk(cs_low_cnt == 32, "R3 chained select ticks", cs_low_cnt, 32);
        chk(cs_rise_cnt == 1, "R3 select gaps", cs_rise_cnt, 1);
    endtask

    task automatic run_read(input int n, input bit rnd_rdy, input string tag);
        int gbase = got_n;
        int ebase = ext_rd_idx;
        int t = 0;
        clear_counts();
        rxr_rand = rnd_rdy; tx_en = 0;
        dir_write = 1'b0;
        while (got_n < gbase + n && t < 20000) begin @(posedge clk); t++; end
        #1 dir_write = 1'b1;
        idle_ticks(12);
        rxr_rand = 0;
        idle_ticks(4);
        chk(got_n >= gbase + n, {tag, " byte count"}, got_n - gbase, n);
        for (int i = 0; i < n; i++)
            chk(got[(gbase + i) % 64] == ext_byte(ebase + i), {tag, " order"},
                got[(gbase + i) % 64], ext_byte(ebase + i));
        chk(got_n - gbase == ext_rd_idx - ebase, {tag, " no loss or repeat"},
            got_n - gbase, ext_rd_idx - ebase);
        chk(offset_bad == 0, "R2 read strobe offset", offset_bad, 0);
        chk(width_bad == 0, "R2 read strobe width", width_bad, 0);
        chk(bus_bad == 0, "R9 bus released on read", bus_bad, 0);
        chk(txr_bad == 0, "R8 no tx_ready in read mode", txr_bad, 0);
    endtask

    task automatic t_busy_write();
        run_write(16, 1, "R7 busy write");
    endtask

    task automatic t_read();
        run_read(8, 0, "R5 read");
    endtask

    task automatic t_read_stall();
        run_read(12, 1, "R6 stalled read");
    endtask

    task automatic t_dir_switch();
        run_write(4, 0, "R8 switch to write");
        chk(cs_low_cnt == 16, "R8 switch cycle count", cs_low_cnt, 16);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_write_burst();
        t_read();
        t_busy_write();
        t_read_stall();
        t_dir_switch();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule